// File: doc/BRIEF.md
# XON/XOFF Receive Flow Detector

This block sits between a UART receiver and its receive FIFO. Each received character arrives as a parallel word with a one-cycle valid strobe. The block decides whether the character is in-band flow control or ordinary data. Flow characters are matched against four programmable patterns: two resume codes and two pause codes. Matching happens either one character at a time or as a pair of consecutive characters. A pause match raises `tx_pause`, and the local transmitter stops once its current character has finished. A resume match lowers `tx_pause` again. Characters used up by a match never reach the FIFO. Every other character is forwarded through a registered push strobe.

There are two further modes. Any-character-resume lets any received character end a pause. Special-character mode never pauses anything. Instead it flags each incoming character that equals the second pause pattern, and still stores that character. Only the low-order bits selected by the configured word length take part in a comparison. A status flag records the last flow event, and the interrupt output mirrors it when enabled.

Top module: `rx_flow_detect`

## Requirements
- R1: Comparisons use only the low 5+`cfg_wlen` bits (`cfg_wlen` 0..3 selects 5, 6, 7 or 8 bits). Bit 0 of every pattern aligns with bit 0 of the received word. Higher bits are ignored.
- R2: All four patterns reset to zero. A write with `pat_we` stores `pat_wdata` into slot `pat_sel` (0 first resume, 1 second resume, 2 first pause, 3 second pause), and the new value is used from the next cycle.
- R3: With `cfg_mode`=0 (pass-through), every character is pushed in the cycle after its strobe and `tx_pause` is low. A pause present when leaving modes 1 and 2 is dropped one cycle later.
- R4: With `cfg_mode`=1 (single), a character matching the first pause pattern sets `tx_pause` and the flag in the cycle after the strobe, and is not pushed. If a character matches both first patterns, the pause match wins.
- R5: In single mode, a character matching the first resume pattern clears `tx_pause` and the flag, and is not pushed. Any other character is pushed and leaves `tx_pause` unchanged.
- R6: With `cfg_mode`=2 (pair), the pause pair (first then second pause pattern, consecutively) sets `tx_pause` and the flag. The resume pair clears them. Neither character of a completed pair is pushed.
- R7: In pair mode, a held first character that is not completed is pushed in the cycle after the second strobe. The second character is then tested as a new first character: it is held if it matches, and otherwise pushed one cycle later. Strobes must be at least two cycles apart.
- R8: With `cfg_any_resume` high in modes 1 or 2, any character received while paused clears `tx_pause` and the flag, unless it completes a pause match. A character that is not a flow match is also pushed.
- R9: With `cfg_mode`=3 (special), every character is pushed. One that matches the second pause pattern sets the flag. `tx_pause` stays low.
- R10: `irq` equals the flag gated by `cfg_irq_en`. `flag_clr` clears the flag one cycle later, and a simultaneous set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| cfg_mode | input | 2 | 0 pass, 1 single, 2 pair, 3 special |
| cfg_any_resume | input | 1 | Any character ends a pause |
| cfg_wlen | input | 2 | Word length code, 5+value bits |
| cfg_irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the status flag |
| pat_we | input | 1 | Pattern write strobe |
| pat_sel | input | 2 | Pattern slot |
| pat_wdata | input | DATA_W | Pattern write data |
| tx_pause | output | 1 | Hold the transmitter after its current character |
| fifo_push | output | 1 | Push strobe to receive FIFO |
| fifo_data | output | DATA_W | Character to push |
| flow_flag | output | 1 | Flow / special-character status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit character width. At that width all 256 codes can be swept at each of the four word lengths against a pattern with mixed high and low bits, which makes the masking boundary at every length visible through the flag. Short directed sequences cover the other requirements. They cover pause priority, broken pairs whose second character may or may not start a new pair, pairs that complete after a broken one, any-character resume, and leaving flow mode while paused.

// File: rtl/rxflow_pkg.sv
package rxflow_pkg;
    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_SINGLE  = 2'd1,
        MODE_DOUBLE  = 2'd2,
        MODE_SPECIAL = 2'd3
    } flow_mode_e;

    localparam int NUM_PAT  = 4;
    localparam int PAT_ON1  = 0;
    localparam int PAT_ON2  = 1;
    localparam int PAT_OFF1 = 2;
    localparam int PAT_OFF2 = 3;
endpackage

// File: rtl/rxflow_patregs.sv
module rxflow_patregs #(
    parameter int DATA_W  = 8,
    parameter int NUM_PAT = 4,
    localparam int SEL_W  = $clog2(NUM_PAT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [SEL_W-1:0]               sel,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_PAT-1:0][DATA_W-1:0] pat
);
    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        logic [DATA_W-1:0] pat_d, pat_q;

        always_comb begin
            pat_d = pat_q;
            if (we && (sel == SEL_W'(g))) pat_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pat_q <= '0;
            else        pat_q <= pat_d;
        end

        assign pat[g] = pat_q;
    end

    // R2: a written slot holds the written value one cycle later
    assert_pat_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> pat[$past(sel)] == $past(wdata));
endmodule

// File: rtl/rxflow_cmp.sv
module rxflow_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] char_in,
    input  logic [DATA_W-1:0] pattern,
    input  logic [DATA_W-1:0] mask,
    output logic              hit
);
    assign hit = ((char_in ^ pattern) & mask) == '0;
endmodule

// File: rtl/rx_flow_detect.sv
module rx_flow_detect
    import rxflow_pkg::*;
#(
    parameter int DATA_W   = 8,
    localparam int WLEN_MIN = DATA_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_any_resume,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_irq_en,
    input  logic              flag_clr,
    input  logic              pat_we,
    input  logic [1:0]        pat_sel,
    input  logic [DATA_W-1:0] pat_wdata,
    output logic              tx_pause,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    output logic              flow_flag,
    output logic              irq
);
    typedef struct packed {
        logic              pause;
        logic              flag;
        logic              pend_v;
        logic              pend_off;
        logic [DATA_W-1:0] pend_data;
        logic              push;
        logic [DATA_W-1:0] push_data;
        logic              spill_v;
        logic [DATA_W-1:0] spill_data;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_PAT-1:0][DATA_W-1:0] pat;
    logic [NUM_PAT-1:0]             hit;
    logic [DATA_W-1:0]              mask;
    flow_mode_e                     mode;
    logic                           flow_on;

    assign mode    = flow_mode_e'(cfg_mode);
    assign flow_on = (mode == MODE_SINGLE) || (mode == MODE_DOUBLE);
    assign mask    = ~({DATA_W{1'b1}} << (WLEN_MIN + int'(cfg_wlen)));

    rxflow_patregs #(.DATA_W(DATA_W), .NUM_PAT(NUM_PAT)) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pat_we),
        .sel   (pat_sel),
        .wdata (pat_wdata),
        .pat   (pat)
    );

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_cmp
        rxflow_cmp #(.DATA_W(DATA_W)) u_cmp (
            .char_in (rx_data),
            .pattern (pat[g]),
            .mask    (mask),
            .hit     (hit[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.push = 1'b0;

        if (s_q.spill_v) begin
            s_d.push      = 1'b1;
            s_d.push_data = s_q.spill_data;
            s_d.spill_v   = 1'b0;
        end

        if (!flow_on)            s_d.pause  = 1'b0;
        if (mode != MODE_DOUBLE) s_d.pend_v = 1'b0;
        if (flag_clr)            s_d.flag   = 1'b0;

        if (rx_valid) begin
            if (flow_on && cfg_any_resume && s_q.pause) begin
                s_d.pause = 1'b0;
                s_d.flag  = 1'b0;
            end
            unique case (mode)
                MODE_PASS: begin
                    s_d.push      = 1'b1;
                    s_d.push_data = rx_data;
                end
                MODE_SPECIAL: begin
                    s_d.push      = 1'b1;
                    s_d.push_data = rx_data;
                    if (hit[PAT_OFF2]) s_d.flag = 1'b1;
                end
                MODE_SINGLE: begin
                    if (hit[PAT_OFF1]) begin
                        s_d.pause = 1'b1;
                        s_d.flag  = 1'b1;
                    end else if (hit[PAT_ON1]) begin
                        s_d.pause = 1'b0;
                        s_d.flag  = 1'b0;
                    end else begin
                        s_d.push      = 1'b1;
                        s_d.push_data = rx_data;
                    end
                end
                MODE_DOUBLE: begin
                    if (s_q.pend_v && (s_q.pend_off ? hit[PAT_OFF2] : hit[PAT_ON2])) begin
                        s_d.pend_v = 1'b0;
                        s_d.pause  = s_q.pend_off;
                        s_d.flag   = s_q.pend_off;
                    end else begin
                        if (s_q.pend_v) begin
                            s_d.push      = 1'b1;
                            s_d.push_data = s_q.pend_data;
                        end
                        if (hit[PAT_OFF1] || hit[PAT_ON1]) begin
                            s_d.pend_v    = 1'b1;
                            s_d.pend_off  = hit[PAT_OFF1];
                            s_d.pend_data = rx_data;
                        end else begin
                            s_d.pend_v = 1'b0;
                            if (s_q.pend_v) begin
                                s_d.spill_v    = 1'b1;
                                s_d.spill_data = rx_data;
                            end else begin
                                s_d.push      = 1'b1;
                                s_d.push_data = rx_data;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_pause  = s_q.pause;
    assign fifo_push = s_q.push;
    assign fifo_data = s_q.push_data;
    assign flow_flag = s_q.flag;
    assign irq       = s_q.flag & cfg_irq_en;

    // R7: strobes are spaced so a deferred push never meets a new character
    assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.spill_v |-> !rx_valid);
    // R7: a push not caused by a strobe is the second half of a split pair
    assert_push_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !$past(rx_valid)) |-> $past(fifo_push));
    // R3: pause only survives while a flow mode was selected
    assert_pause_flow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pause |-> $past(flow_on));
    // R5: pause ends only on a received character or leaving flow mode
    assert_pause_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_pause) |-> ($past(rx_valid) || !$past(flow_on)));
    // R4: the flag is only raised by a received character
    assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flow_flag) |-> $past(rx_valid));
endmodule

// File: tb/rx_flow_detect_tb.sv
module rx_flow_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [1:0] cfg_mode = '0;
    logic       cfg_any_resume = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       pat_we = 1'b0;
    logic [1:0] pat_sel = '0;
    logic [7:0] pat_wdata = '0;
    logic       tx_pause, fifo_push, flow_flag, irq;
    logic [7:0] fifo_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic       p0, p1;
    logic [7:0] d0, d1;

    always #4 clk = ~clk;

    rx_flow_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .cfg_mode(cfg_mode), .cfg_any_resume(cfg_any_resume), .cfg_wlen(cfg_wlen),
        .cfg_irq_en(cfg_irq_en), .flag_clr(flag_clr), .pat_we(pat_we),
        .pat_sel(pat_sel), .pat_wdata(pat_wdata), .tx_pause(tx_pause),
        .fifo_push(fifo_push), .fifo_data(fifo_data), .flow_flag(flow_flag), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = c;
        @(negedge clk);
        rx_valid = 1'b0;
        p0 = fifo_push; d0 = fifo_data;
        @(negedge clk);
        p1 = fifo_push; d1 = fifo_data;
    endtask

    task automatic wr_pat(input logic [1:0] sel, input logic [7:0] v);
        @(negedge clk);
        pat_we = 1'b1; pat_sel = sel; pat_wdata = v;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset pause", tx_pause, 0);
        check("reset flag", flow_flag, 0);
        check("reset push", fifo_push, 0);
        check("reset irq", irq, 0);

        // R2: patterns are zero after reset, so 0x00 is a pause code
        cfg_mode = 2'd1;
        send(8'h00);
        check("R2 zero pattern pauses", tx_pause, 1);
        check("R2 zero char not pushed", p0, 0);
        check("R4 flag set", flow_flag, 1);
        check("R10 irq gated off", irq, 0);
        cfg_irq_en = 1'b1;
        #1;
        check("R10 irq enabled", irq, 1);
        clr_flag();
        check("R10 flag_clr", flow_flag, 0);
        check("R10 pause kept after clear", tx_pause, 1);

        wr_pat(2'd0, 8'h11);
        wr_pat(2'd1, 8'h12);
        wr_pat(2'd2, 8'h13);
        wr_pat(2'd3, 8'h14);

        // R5 / R4 single-character mode
        send(8'h11);
        check("R5 resume", tx_pause, 0);
        check("R5 resume not pushed", p0, 0);
        send(8'h13);
        check("R4 pause", tx_pause, 1);
        check("R4 pause char not pushed", p0, 0);
        check("R4 flag", flow_flag, 1);
        send(8'h41);
        check("R5 data pushed", p0, 1);
        check("R5 data value", d0, 8'h41);
        check("R5 data keeps pause", tx_pause, 1);
        send(8'h11);
        check("R5 resume again", tx_pause, 0);
        check("R5 resume clears flag", flow_flag, 0);

        // R3 pass-through and leaving flow mode
        send(8'h13);
        check("R3 paused before switch", tx_pause, 1);
        cfg_mode = 2'd0;
        @(negedge clk);
        check("R3 pause dropped", tx_pause, 0);
        send(8'h13);
        check("R3 pass push", p0, 1);
        check("R3 pass data", d0, 8'h13);
        check("R3 pass no pause", tx_pause, 0);
        clr_flag();

        // R6 pair mode
        cfg_mode = 2'd2;
        send(8'h13);
        check("R6 first held", p0 | p1, 0);
        check("R6 no pause yet", tx_pause, 0);
        send(8'h14);
        check("R6 pause pair", tx_pause, 1);
        check("R6 pair not pushed", p0 | p1, 0);
        send(8'h11);
        send(8'h12);
        check("R6 resume pair", tx_pause, 0);
        check("R6 resume not pushed", p0 | p1, 0);

        // R7 broken pairs
        send(8'h13);
        send(8'h55);
        check("R7 held pushed", p0, 1);
        check("R7 held value", d0, 8'h13);
        check("R7 second pushed later", p1, 1);
        check("R7 second value", d1, 8'h55);
        send(8'h13);
        send(8'h11);
        check("R7 held pushed before new first", p0, 1);
        check("R7 held value 2", d0, 8'h13);
        check("R7 new first kept", p1, 0);
        send(8'h12);
        check("R7 restarted pair completes", p0 | p1, 0);
        check("R7 still running", tx_pause, 0);
        send(8'h13);
        send(8'h13);
        check("R7 repeat first pushed", d0, 8'h13);
        check("R7 repeat kept", p1, 0);
        send(8'h14);
        check("R7 pair after repeat", tx_pause, 1);

        // R8 any-character resume
        cfg_mode = 2'd1;
        cfg_any_resume = 1'b1;
        send(8'h77);
        check("R8 any resumes", tx_pause, 0);
        check("R8 flag cleared", flow_flag, 0);
        check("R8 char pushed", p0, 1);
        check("R8 char value", d0, 8'h77);
        send(8'h13);
        check("R8 pause again", tx_pause, 1);
        send(8'h13);
        check("R8 pause code keeps pause", tx_pause, 1);
        check("R8 pause code not pushed", p0, 0);
        cfg_any_resume = 1'b0;

        // R9 / R1 special mode sweep over all codes and word lengths
        cfg_mode = 2'd3;
        wr_pat(2'd3, 8'hB4);
        @(negedge clk);
        clr_flag();
        for (int w = 0; w < 4; w++) begin
            cfg_wlen = 2'(w);
            for (int c = 0; c < 256; c++) begin
                logic [7:0] m;
                m = 8'((1 << (5 + w)) - 1);
                send(8'(c));
                check("R1 masked compare", flow_flag, (((c ^ 8'hB4) & m) == 0) ? 1 : 0);
                check("R9 always pushed", p0, 1);
                check("R9 pushed value", d0, c);
                check("R9 no pause", tx_pause, 0);
                clr_flag();
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule